// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM with Parity Field

This block is a synchronous two-port memory holding 16,384 data bits plus a 2,048-bit parity field. Each port has its own clock, enable, write enable, synchronous output clear, address, data and parity inputs, and registered data and parity outputs. A parameter picks each port's width separately from 1, 2, 4, 9, 18 or 36 bits, and the depth follows from that width. Both ports see one shared bit layout, so a word written at one width can be read back at another width through the other port.

Storage is kept as 512 rows of 36 bits: 32 data bits and 4 parity bits per row. A narrow port selects a lane inside a row. The wider settings (9, 18 and 36) carry one parity bit for each byte of data. The narrower settings have no parity. Each port writes with one-clock, write-first behaviour. Its output register can be cleared without disturbing the stored contents.

Top module: `dpram_dual`

## Requirements
- R1: While rst_ni is low, every data and parity output is 0, and it is cleared asynchronously.
- R2: The width parameter sets the port geometry. Width 1 gives a 14-bit address, width 2 a 13-bit address, width 4 a 12-bit address. Width 9 gives 8 data bits, 1 parity bit and an 11-bit address. Width 18 gives 16 data bits, 2 parity bits and a 10-bit address. Width 36 gives 32 data bits, 4 parity bits and a 9-bit address. The highest address of each geometry reaches the last bits of the array.
- R3: Let D be a port's data width without parity and P its parity width. Data bit i at address a is array bit a*D+i, and parity bit j at address a is parity bit a*P+j. The layout is the same for both ports.
- R4: A read with enable high and write enable low presents the addressed word on the outputs one clock edge later.
- R5: A write with enable high stores the word on the edge and also drives the written data and parity onto that port's own outputs on the same edge.
- R6: With enable low, a port neither writes nor changes its outputs, even when write enable is high.
- R7: With enable high, the clear input drives that port's outputs to 0 on the next edge. It leaves stored contents unchanged, and a write requested in the same cycle is still stored.
- R8: For widths 1, 2 and 4, the single-bit parity input is ignored and never changes stored parity, and the parity output stays 0.
- R9: The two ports may read or write different rows on the same edge, each with its own correct result.
- R10: When the ports share a clock edge and one writes a location that the other reads, the reader returns the previous contents. Two writes to the same 36-bit row on the same edge leave that row undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the output registers |
| en_a_i | input | 1 | Port A enable |
| we_a_i | input | 1 | Port A write enable |
| srst_a_i | input | 1 | Port A synchronous output clear |
| addr_a_i | input | AW_A | Port A address |
| din_a_i | input | DW_A | Port A write data |
| pin_a_i | input | PX_A | Port A write parity (1 bit, unused, for narrow widths) |
| dout_a_o | output | DW_A | Port A read data |
| pout_a_o | output | PX_A | Port A read parity |
| en_b_i | input | 1 | Port B enable |
| we_b_i | input | 1 | Port B write enable |
| srst_b_i | input | 1 | Port B synchronous output clear |
| addr_b_i | input | AW_B | Port B address |
| din_b_i | input | DW_B | Port B write data |
| pin_b_i | input | PX_B | Port B write parity |
| dout_b_o | output | DW_B | Port B read data |
| pout_b_o | output | PX_B | Port B read parity |

## Verification
The bench uses two instances, one with widths 36 and 9 and one with widths 4 and 18. It writes at one width and reads back at the other. This exposes a wrong lane order or a wrong parity-bit position as bytes or nibbles in the wrong place. It also writes single lanes into words that are already full, so a lane write that clobbers its neighbours shows up as corrupted adjacent data. The top address of each geometry is exercised, which catches an address slice that drops or shifts a bit. Separate cases cover a disabled write that still stores or moves the output, a clear that also wipes memory or blocks a write, parity leaking through a narrow port, and a same-edge read of a word being written that returns the new value instead of the old one.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int ROW_N  = 512;
  localparam int ROW_AW = $clog2(ROW_N);
  localparam int ROW_DW = 32;
  localparam int ROW_PW = ROW_DW / 8;
  localparam int ROW_W  = ROW_DW + ROW_PW;

  function automatic int data_w(int w);
    case (w)
      1:  return 1;
      2:  return 2;
      4:  return 4;
      9:  return 8;
      18: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int par_w(int w);
    case (w)
      9:  return 1;
      18: return 2;
      36: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int port_pw(int w);
    return (par_w(w) == 0) ? 1 : par_w(w);
  endfunction

  function automatic int lane_bits(int w);
    return $clog2(ROW_DW / data_w(w));
  endfunction

  function automatic int addr_w(int w);
    return ROW_AW + lane_bits(w);
  endfunction
endpackage

// File: rtl/dpram_bank.sv
// One storage bank, written from a single clock domain, read combinationally at both row addresses.
module dpram_bank
  import dpram_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_AW-1:0] waddr_i,
  input  logic [ROW_W-1:0]  wdata_i,
  input  logic [ROW_AW-1:0] raddr_a_i,
  input  logic [ROW_AW-1:0] raddr_b_i,
  output logic [ROW_W-1:0]  rdata_a_o,
  output logic [ROW_W-1:0]  rdata_b_o
);
  logic [ROW_W-1:0] mem_q [ROW_N];

  initial begin
    for (int r = 0; r < ROW_N; r++) mem_q[r] = '0;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/dpram_port.sv
// Lane select, read-modify merge and output register for one port.
module dpram_port
  import dpram_pkg::*;
#(
  parameter  int WIDTH = 36,
  localparam int DW    = data_w(WIDTH),
  localparam int PW    = par_w(WIDTH),
  localparam int PX    = port_pw(WIDTH),
  localparam int LB    = lane_bits(WIDTH),
  localparam int AW    = addr_w(WIDTH),
  localparam int LBX   = (LB > 0) ? LB : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic              srst_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     din_i,
  input  logic [PX-1:0]     pin_i,
  input  logic [ROW_W-1:0]  own_row_i,
  input  logic [ROW_W-1:0]  peer_row_i,
  output logic [ROW_AW-1:0] row_o,
  output logic              wr_o,
  output logic [ROW_W-1:0]  wrow_o,
  output logic [DW-1:0]     dout_o,
  output logic [PX-1:0]     pout_o
);
  logic [LBX-1:0]    lane;
  logic [ROW_W-1:0]  cur;
  logic [ROW_DW-1:0] dmask, new_d, rd_d;
  logic [ROW_PW-1:0] new_p;
  logic [PX-1:0]     rd_p, wf_p;
  int                sh_d;

  if (LB > 0) begin : g_lane
    assign lane = addr_i[LBX-1:0];
  end else begin : g_nolane
    assign lane = '0;
  end

  assign row_o = addr_i[AW-1 -: ROW_AW];
  // Stored value is the XOR of both banks (R3, R10)
  assign cur   = own_row_i ^ peer_row_i;
  assign sh_d  = int'(lane) * DW;
  assign dmask = ROW_DW'({DW{1'b1}}) << sh_d;
  assign new_d = (cur[ROW_DW-1:0] & ~dmask) | (ROW_DW'(din_i) << sh_d);
  assign rd_d  = cur[ROW_DW-1:0] >> sh_d;

  if (PW > 0) begin : g_par
    int                sh_p;
    logic [ROW_PW-1:0] pmask, rd_pf;
    assign sh_p  = int'(lane) * PW;
    assign pmask = ROW_PW'({PW{1'b1}}) << sh_p;
    assign new_p = (cur[ROW_W-1:ROW_DW] & ~pmask) | (ROW_PW'(pin_i) << sh_p);
    assign rd_pf = cur[ROW_W-1:ROW_DW] >> sh_p;
    assign rd_p  = rd_pf[PX-1:0];
    assign wf_p  = pin_i;
  end else begin : g_nopar
    // R8: narrow widths keep stored parity and report zero
    logic unused_pin;
    assign unused_pin = ^pin_i;
    assign new_p = cur[ROW_W-1:ROW_DW];
    assign rd_p  = '0;
    assign wf_p  = '0;
  end

  assign wr_o   = en_i & we_i;
  // Own bank stores desired ^ peer so that the XOR of the two banks yields the new row
  assign wrow_o = {new_p, new_d} ^ peer_row_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= '0;
      pout_o <= '0;
    end else if (en_i) begin
      if (srst_i) begin
        dout_o <= '0;
        pout_o <= '0;
      end else if (we_i) begin
        dout_o <= din_i;
        pout_o <= wf_p;
      end else begin
        dout_o <= rd_d[DW-1:0];
        pout_o <= rd_p;
      end
    end
  end
endmodule

// File: rtl/dpram_dual.sv
module dpram_dual
  import dpram_pkg::*;
#(
  parameter  int WIDTH_A = 36,
  parameter  int WIDTH_B = 9,
  localparam int AW_A    = addr_w(WIDTH_A),
  localparam int DW_A    = data_w(WIDTH_A),
  localparam int PX_A    = port_pw(WIDTH_A),
  localparam int AW_B    = addr_w(WIDTH_B),
  localparam int DW_B    = data_w(WIDTH_B),
  localparam int PX_B    = port_pw(WIDTH_B)
) (
  input  logic            clk_a_i,
  input  logic            clk_b_i,
  input  logic            rst_ni,
  input  logic            en_a_i,
  input  logic            we_a_i,
  input  logic            srst_a_i,
  input  logic [AW_A-1:0] addr_a_i,
  input  logic [DW_A-1:0] din_a_i,
  input  logic [PX_A-1:0] pin_a_i,
  output logic [DW_A-1:0] dout_a_o,
  output logic [PX_A-1:0] pout_a_o,
  input  logic            en_b_i,
  input  logic            we_b_i,
  input  logic            srst_b_i,
  input  logic [AW_B-1:0] addr_b_i,
  input  logic [DW_B-1:0] din_b_i,
  input  logic [PX_B-1:0] pin_b_i,
  output logic [DW_B-1:0] dout_b_o,
  output logic [PX_B-1:0] pout_b_o
);
  logic [ROW_AW-1:0] row_a, row_b;
  logic              wr_a, wr_b;
  logic [ROW_W-1:0]  wrow_a, wrow_b;
  logic [ROW_W-1:0]  ba_at_a, ba_at_b, bb_at_a, bb_at_b;

  dpram_bank u_bank_a (
    .clk_i     (clk_a_i),
    .we_i      (wr_a),
    .waddr_i   (row_a),
    .wdata_i   (wrow_a),
    .raddr_a_i (row_a),
    .raddr_b_i (row_b),
    .rdata_a_o (ba_at_a),
    .rdata_b_o (ba_at_b)
  );

  dpram_bank u_bank_b (
    .clk_i     (clk_b_i),
    .we_i      (wr_b),
    .waddr_i   (row_b),
    .wdata_i   (wrow_b),
    .raddr_a_i (row_a),
    .raddr_b_i (row_b),
    .rdata_a_o (bb_at_a),
    .rdata_b_o (bb_at_b)
  );

  dpram_port #(.WIDTH(WIDTH_A)) u_port_a (
    .clk_i      (clk_a_i),
    .rst_ni     (rst_ni),
    .en_i       (en_a_i),
    .we_i       (we_a_i),
    .srst_i     (srst_a_i),
    .addr_i     (addr_a_i),
    .din_i      (din_a_i),
    .pin_i      (pin_a_i),
    .own_row_i  (ba_at_a),
    .peer_row_i (bb_at_a),
    .row_o      (row_a),
    .wr_o       (wr_a),
    .wrow_o     (wrow_a),
    .dout_o     (dout_a_o),
    .pout_o     (pout_a_o)
  );

  dpram_port #(.WIDTH(WIDTH_B)) u_port_b (
    .clk_i      (clk_b_i),
    .rst_ni     (rst_ni),
    .en_i       (en_b_i),
    .we_i       (we_b_i),
    .srst_i     (srst_b_i),
    .addr_i     (addr_b_i),
    .din_i      (din_b_i),
    .pin_i      (pin_b_i),
    .own_row_i  (bb_at_b),
    .peer_row_i (ba_at_b),
    .row_o      (row_b),
    .wr_o       (wr_b),
    .wrow_o     (wrow_b),
    .dout_o     (dout_b_o),
    .pout_o     (pout_b_o)
  );
endmodule

// File: rtl/dpram_dual_chk.sv
module dpram_dual_chk
  import dpram_pkg::*;
#(
  parameter  int WIDTH_A = 36,
  parameter  int WIDTH_B = 9,
  localparam int DW_A    = data_w(WIDTH_A),
  localparam int PX_A    = port_pw(WIDTH_A),
  localparam int DW_B    = data_w(WIDTH_B),
  localparam int PX_B    = port_pw(WIDTH_B)
) (
  input logic            clk_a_i,
  input logic            clk_b_i,
  input logic            rst_ni,
  input logic            en_a_i,
  input logic            we_a_i,
  input logic            srst_a_i,
  input logic [DW_A-1:0] din_a_i,
  input logic [PX_A-1:0] pin_a_i,
  input logic [DW_A-1:0] dout_a_o,
  input logic [PX_A-1:0] pout_a_o,
  input logic            en_b_i,
  input logic            we_b_i,
  input logic            srst_b_i,
  input logic [DW_B-1:0] din_b_i,
  input logic [PX_B-1:0] pin_b_i,
  input logic [DW_B-1:0] dout_b_o,
  input logic [PX_B-1:0] pout_b_o
);
  p_rst_clear_a_r1: assert property (@(posedge clk_a_i)
    !rst_ni |-> (dout_a_o == '0 && pout_a_o == '0));
  p_rst_clear_b_r1: assert property (@(posedge clk_b_i)
    !rst_ni |-> (dout_b_o == '0 && pout_b_o == '0));

  p_write_first_a_r5: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (en_a_i && we_a_i && !srst_a_i) |=> dout_a_o == $past(din_a_i));
  p_write_first_b_r5: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (en_b_i && we_b_i && !srst_b_i) |=> dout_b_o == $past(din_b_i));

  p_hold_a_r6: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !en_a_i |=> ($stable(dout_a_o) && $stable(pout_a_o)));
  p_hold_b_r6: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !en_b_i |=> ($stable(dout_b_o) && $stable(pout_b_o)));

  p_clear_a_r7: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (en_a_i && srst_a_i) |=> (dout_a_o == '0 && pout_a_o == '0));
  p_clear_b_r7: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (en_b_i && srst_b_i) |=> (dout_b_o == '0 && pout_b_o == '0));

  if (par_w(WIDTH_A) == 0) begin : g_quiet_a
    p_par_quiet_a_r8: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
      (en_a_i && we_a_i && pin_a_i != '0) |=> pout_a_o == '0);
  end else begin : g_wf_par_a
    p_par_first_a_r5: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
      (en_a_i && we_a_i && !srst_a_i) |=> pout_a_o == $past(pin_a_i));
  end

  if (par_w(WIDTH_B) == 0) begin : g_quiet_b
    p_par_quiet_b_r8: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
      (en_b_i && we_b_i && pin_b_i != '0) |=> pout_b_o == '0);
  end else begin : g_wf_par_b
    p_par_first_b_r5: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
      (en_b_i && we_b_i && !srst_b_i) |=> pout_b_o == $past(pin_b_i));
  end
endmodule

bind dpram_dual dpram_dual_chk #(.WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) u_chk (
  .clk_a_i  (clk_a_i),
  .clk_b_i  (clk_b_i),
  .rst_ni   (rst_ni),
  .en_a_i   (en_a_i),
  .we_a_i   (we_a_i),
  .srst_a_i (srst_a_i),
  .din_a_i  (din_a_i),
  .pin_a_i  (pin_a_i),
  .dout_a_o (dout_a_o),
  .pout_a_o (pout_a_o),
  .en_b_i   (en_b_i),
  .we_b_i   (we_b_i),
  .srst_b_i (srst_b_i),
  .din_b_i  (din_b_i),
  .pin_b_i  (pin_b_i),
  .dout_b_o (dout_b_o),
  .pout_b_o (pout_b_o)
);

// File: tb/dpram_dual_test.sv
module dpram_dual_test;
  localparam int HALF = 10; // 20 ns period, 50 MHz

  typedef struct {
    bit          en;
    bit          we;
    bit          srst;
    int          addr;
    logic [31:0] d;
    logic [3:0]  p;
  } cmd_t;

  typedef struct {
    int          due;
    int          inst;
    int          pt;
    logic [31:0] d;
    logic [3:0]  p;
    int          req;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  logic        en_s   [2][2];
  logic        we_s   [2][2];
  logic        srst_s [2][2];
  logic [13:0] addr_s [2][2];
  logic [31:0] din_s  [2][2];
  logic [3:0]  pin_s  [2][2];
  logic [31:0] obs_d  [2][2];
  logic [3:0]  obs_p  [2][2];

  logic [31:0] d0a; logic [3:0] p0a;
  logic [7:0]  d0b; logic [0:0] p0b;
  logic [3:0]  d1a; logic [0:0] p1a;
  logic [15:0] d1b; logic [1:0] p1b;

  logic [16383:0] md [2];
  logic [2047:0]  mp [2];
  logic [31:0]    exp_d [2][2];
  logic [3:0]     exp_p [2][2];
  item_t          sb_q [$];

  always #HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpram_dual #(.WIDTH_A(36), .WIDTH_B(9)) uut (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_ni),
    .en_a_i(en_s[0][0]), .we_a_i(we_s[0][0]), .srst_a_i(srst_s[0][0]),
    .addr_a_i(addr_s[0][0][8:0]), .din_a_i(din_s[0][0]), .pin_a_i(pin_s[0][0]),
    .dout_a_o(d0a), .pout_a_o(p0a),
    .en_b_i(en_s[0][1]), .we_b_i(we_s[0][1]), .srst_b_i(srst_s[0][1]),
    .addr_b_i(addr_s[0][1][10:0]), .din_b_i(din_s[0][1][7:0]), .pin_b_i(pin_s[0][1][0:0]),
    .dout_b_o(d0b), .pout_b_o(p0b)
  );

  dpram_dual #(.WIDTH_A(4), .WIDTH_B(18)) uut_n (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_ni),
    .en_a_i(en_s[1][0]), .we_a_i(we_s[1][0]), .srst_a_i(srst_s[1][0]),
    .addr_a_i(addr_s[1][0][11:0]), .din_a_i(din_s[1][0][3:0]), .pin_a_i(pin_s[1][0][0:0]),
    .dout_a_o(d1a), .pout_a_o(p1a),
    .en_b_i(en_s[1][1]), .we_b_i(we_s[1][1]), .srst_b_i(srst_s[1][1]),
    .addr_b_i(addr_s[1][1][9:0]), .din_b_i(din_s[1][1][15:0]), .pin_b_i(pin_s[1][1][1:0]),
    .dout_b_o(d1b), .pout_b_o(p1b)
  );

  assign obs_d[0][0] = d0a;           assign obs_p[0][0] = p0a;
  assign obs_d[0][1] = {24'b0, d0b};  assign obs_p[0][1] = {3'b0, p0b};
  assign obs_d[1][0] = {28'b0, d1a};  assign obs_p[1][0] = {3'b0, p1a};
  assign obs_d[1][1] = {16'b0, d1b};  assign obs_p[1][1] = {2'b0, p1b};

  function automatic int wid(int inst, int pt);
    if (inst == 0) return (pt == 0) ? 36 : 9;
    return (pt == 0) ? 4 : 18;
  endfunction
  function automatic int dw_of(int w);
    return (w == 36) ? 32 : (w == 18) ? 16 : (w == 9) ? 8 : w;
  endfunction
  function automatic int pw_of(int w);
    return (w == 36) ? 4 : (w == 18) ? 2 : (w == 9) ? 1 : 0;
  endfunction

  function automatic cmd_t mk(bit en, bit we, bit sr, int a, logic [31:0] d, logic [3:0] p);
    cmd_t c;
    c.en = en; c.we = we; c.srst = sr; c.addr = a; c.d = d; c.p = p;
    return c;
  endfunction
  function automatic cmd_t nop();
    return mk(0, 0, 0, 0, 0, 0);
  endfunction
  function automatic cmd_t rd(int a);
    return mk(1, 0, 0, a, 0, 0);
  endfunction
  function automatic cmd_t wr(int a, logic [31:0] d, logic [3:0] p);
    return mk(1, 1, 0, a, d, p);
  endfunction

  task automatic cmp(int req, int inst, int pt, logic [31:0] ed, logic [3:0] ep);
    checks++;
    if (obs_d[inst][pt] !== ed || obs_p[inst][pt] !== ep) begin
      errors++;
      $display("FAIL R%0d inst %0d port %0d: data %h exp %h, parity %h exp %h",
               req, inst, pt, obs_d[inst][pt], ed, obs_p[inst][pt], ep);
    end
  endtask

  // Monitor: pops expected items as their cycle comes due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      cmp(it.req, it.inst, it.pt, it.d, it.p);
    end
  end

  // Driver: one cycle on one instance; expected outputs pushed to the scoreboard
  task automatic step(int inst, cmd_t ca, cmd_t cb, int req);
    cmd_t c [2];
    logic [31:0] nd [2];
    logic [3:0]  np [2];
    c[0] = ca; c[1] = cb;
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < 2; k++) en_s[i][k] = 1'b0;
    for (int k = 0; k < 2; k++) begin
      en_s[inst][k]   = c[k].en;
      we_s[inst][k]   = c[k].we;
      srst_s[inst][k] = c[k].srst;
      addr_s[inst][k] = 14'(c[k].addr);
      din_s[inst][k]  = c[k].d;
      pin_s[inst][k]  = c[k].p;
    end
    for (int k = 0; k < 2; k++) begin
      int d = dw_of(wid(inst, k));
      int pw = pw_of(wid(inst, k));
      nd[k] = exp_d[inst][k];
      np[k] = exp_p[inst][k];
      if (c[k].en) begin
        nd[k] = '0; np[k] = '0;
        if (!c[k].srst) begin
          for (int i = 0; i < d; i++)
            nd[k][i] = c[k].we ? c[k].d[i] : md[inst][c[k].addr*d+i];
          for (int j = 0; j < pw; j++)
            np[k][j] = c[k].we ? c[k].p[j] : mp[inst][c[k].addr*pw+j];
        end
      end
    end
    for (int k = 0; k < 2; k++) begin
      int d = dw_of(wid(inst, k));
      int pw = pw_of(wid(inst, k));
      if (c[k].en && c[k].we) begin
        for (int i = 0; i < d; i++) md[inst][c[k].addr*d+i] = c[k].d[i];
        for (int j = 0; j < pw; j++) mp[inst][c[k].addr*pw+j] = c[k].p[j];
      end
    end
    for (int k = 0; k < 2; k++) begin
      item_t it;
      exp_d[inst][k] = nd[k];
      exp_p[inst][k] = np[k];
      it.due = cyc + 1; it.inst = inst; it.pt = k;
      it.d = nd[k]; it.p = np[k]; it.req = req;
      sb_q.push_back(it);
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      md[i] = '0; mp[i] = '0;
      for (int k = 0; k < 2; k++) begin
        en_s[i][k] = 0; we_s[i][k] = 0; srst_s[i][k] = 0;
        addr_s[i][k] = '0; din_s[i][k] = '0; pin_s[i][k] = '0;
        exp_d[i][k] = '0; exp_p[i][k] = '0;
      end
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < 2; k++) cmp(1, i, k, 0, 0); // R1 reset state
    rst_ni = 1'b1;
    @(negedge clk);

    // Widths 36 (A) and 9 (B)
    step(0, wr(5, 32'hA1B2C3D4, 4'hA), nop(), 5);       // R5 write-first
    step(0, rd(5), nop(), 4);                           // R4 read latency
    for (int k = 0; k < 4; k++) step(0, nop(), rd(20 + k), 3); // R3 byte lanes and parity
    step(0, nop(), wr(22, 32'h5E, 4'h1), 5);            // R5 narrow write-first
    step(0, rd(5), nop(), 3);                           // R3 lane merge
    step(0, mk(0, 1, 0, 5, 32'h0BAD0BAD, 4'h5), rd(21), 6); // R6 disabled write
    step(0, rd(5), nop(), 6);                           // R6 contents kept
    step(0, mk(1, 0, 1, 5, 0, 0), nop(), 7);            // R7 clear output
    step(0, rd(5), nop(), 7);                           // R7 contents kept
    step(0, mk(1, 1, 1, 7, 32'h13572468, 4'h3), nop(), 7); // R7 clear with write
    step(0, rd(7), nop(), 7);                           // R7 write stored
    step(0, wr(511, 32'hFEDCBA98, 4'h9), rd(20), 9);    // R9 concurrent
    step(0, nop(), rd(2047), 2);                        // R2 last byte
    step(0, wr(300, 32'h00C0FFEE, 4'h6), wr(0, 32'h77, 4'h0), 9); // R9 two writes
    step(0, rd(300), rd(0), 9);                         // R9 readback
    step(0, wr(5, 32'h11223344, 4'h0), rd(20), 10);     // R10 reader sees old
    step(0, nop(), rd(20), 10);                         // R10 new value after

    // Widths 4 (A) and 18 (B)
    step(1, nop(), wr(1, 32'hFFFF, 4'h3), 5);           // R5
    for (int k = 0; k < 4; k++) step(1, wr(4 + k, 32'(k + 1), 4'hF), nop(), 8); // R8 parity quiet
    step(1, nop(), rd(1), 8);                           // R8 parity untouched, R3 nibbles
    step(1, nop(), wr(1023, 32'hBEEF, 4'h1), 2);        // R2 last word
    step(1, rd(4095), nop(), 2);                        // R2 last nibble
    step(1, rd(4094), rd(1023), 2);                     // R2

    // R1 reset during operation
    #1;
    rst_ni = 1'b0;
    #1;
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < 2; k++) begin
        cmp(1, i, k, 0, 0);
        exp_d[i][k] = '0; exp_p[i][k] = '0;
      end
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    step(0, rd(300), nop(), 4);                         // R4 after reset
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule